// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is an SPI master that a processor controls through a small byte-wide register bus. Software programs a configuration byte, a clock divisor and a transmit byte. It then writes a start command, and the block shifts exactly one 8-bit frame out on MOSI while it captures one frame from MISO. The block has no FIFO. Each frame ends with a receive-ready flag and a level interrupt, and software reads the received byte to clear both before it starts the next frame.

The serial clock is derived from the system clock. Each half period of SCK lasts 2·(D+1) system cycles, where D is the divisor byte. A full SCK period is therefore 4·(D+1) cycles. Polarity, phase, bit order and an internal loopback are selected in the configuration byte. The phase control is the inverse of the usual CPHA sense: when it is set, data is captured on the leading edge. The busy flag stays high for one cycle after the cycle in which the frame completes.

Top module: `spi_byte_master`

## Requirements
- R1: Register offsets are: configuration 0, received byte 1, transmit byte 2, command 3, status 4, divisor 6. The configuration register keeps bits [4:0] and reads 0 in bits [7:5]. The transmit byte and the divisor read back as written. Offsets 5 and 7 read 0. After reset every register and the status read 0.
- R2: Writing a command byte with bit 0 set, while configuration bit 3 (port enable) is 1 and the block is idle, starts a frame. Busy (status bit 1) is high from the next cycle.
- R3: The first SCK edge comes 2·(D+1) cycles after the cycle of the start write, and every later edge follows 2·(D+1) cycles after the one before. A frame has 16 edges. This holds for every D from 0 to 255.
- R4: Configuration bit 1 sets the SCK idle level (0 low, 1 high). SCK sits at that level whenever the block is not busy or port enable is 0.
- R5: Configuration bit 4 set: the first data bit is on MOSI before the leading edge, MISO is captured on leading edges, and MOSI changes on trailing edges. Bit 4 clear: MOSI changes on leading edges and MISO is captured on trailing edges. MOSI changes at no other time.
- R6: Configuration bit 2 clear shifts bit 7 first in both directions. When it is set, bit 0 goes first.
- R7: With configuration bit 0 (loopback) set, the received byte equals the transmitted byte and the MISO pin is ignored.
- R8: Receive-ready (status bit 0) and irq rise 16·2·(D+1) cycles after the start write. Busy is still 1 in that cycle and falls in the next.
- R9: A read of offset 1 returns the last received byte and clears receive-ready and irq from the next cycle.
- R10: A start command written while busy is ignored, and the running frame completes at its original time.
- R11: A start command written while port enable is 0 is ignored: busy stays 0, SCK stays idle and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; its side effect (clearing receive-ready) acts at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt, high while a received byte is unread |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Each result has a fixed due cycle. Counting from the clock edge that accepts the start write, the first SCK edge is due at edge 2·(D+1), receive-ready and irq at edge 32·(D+1), and the fall of busy one edge later. The bench counts falling edges after the start write and samples each output at the half period that follows its due edge. It also checks the cycle just before, where each output must still hold its old value. A bench-side SPI slave watches SCK and drives MISO half a cycle after each edge. It captures MOSI at the same time, so received and transmitted bytes are compared only after the frame has ended.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

   // register byte offsets (software decodes these)
   localparam logic [2:0] A_CFG  = 3'd0;
   localparam logic [2:0] A_RXB  = 3'd1;
   localparam logic [2:0] A_TXB  = 3'd2;
   localparam logic [2:0] A_CMD  = 3'd3;
   localparam logic [2:0] A_STAT = 3'd4;
   localparam logic [2:0] A_DIV  = 3'd6;

   localparam int CMD_GO    = 0;
   localparam int STAT_BUSY = 1;
   localparam int STAT_RDY  = 0;
   localparam int REG_W     = 8;

   // configuration byte, field order fixes bit positions 4..0
   typedef struct packed {
      logic lead_cap;   // 1: capture on leading edge
      logic en;         // port enable
      logic lsb;        // bit 0 first
      logic idle;       // SCK idle level
      logic loop;       // MISO taken from MOSI
   } cfg_t;

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} eng_st_t;

endpackage

// File: rtl/spi_bm_regs.sv
module spi_bm_regs
   import spi_bm_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int FRAME_W = 8,
   parameter int DIV_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic               busy,
   input  logic               done,
   input  logic [FRAME_W-1:0] rx_word,
   output cfg_t               cfg,
   output logic [FRAME_W-1:0] tx_word,
   output logic [DIV_W-1:0]   div,
   output logic               start_ok,
   output logic               ready,
   output logic               rx_rd
);

   logic [FRAME_W-1:0] rxb_q;
   logic               hit_cfg, hit_txb, hit_div, hit_cmd;

   assign hit_cfg  = bus_addr == ADDR_W'(A_CFG);
   assign hit_txb  = bus_addr == ADDR_W'(A_TXB);
   assign hit_div  = bus_addr == ADDR_W'(A_DIV);
   assign hit_cmd  = bus_addr == ADDR_W'(A_CMD);
   assign rx_rd    = bus_rd && (bus_addr == ADDR_W'(A_RXB));
   assign start_ok = bus_wr && hit_cmd && bus_wdata[CMD_GO] && cfg.en && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg     <= '0;
         tx_word <= '0;
         div     <= '0;
      end else if (bus_wr) begin
         if (hit_cfg) cfg     <= cfg_t'(bus_wdata[4:0]);
         if (hit_txb) tx_word <= bus_wdata[FRAME_W-1:0];
         if (hit_div) div     <= bus_wdata[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rxb_q <= '0;
         ready <= 1'b0;
      end else if (done) begin
         rxb_q <= rx_word;
         ready <= 1'b1;
      end else if (rx_rd) begin
         ready <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(A_CFG):  bus_rdata[4:0]         = cfg;
         ADDR_W'(A_RXB):  bus_rdata[FRAME_W-1:0] = rxb_q;
         ADDR_W'(A_TXB):  bus_rdata[FRAME_W-1:0] = tx_word;
         ADDR_W'(A_STAT): begin
            bus_rdata[STAT_BUSY] = busy;
            bus_rdata[STAT_RDY]  = ready;
         end
         ADDR_W'(A_DIV):  bus_rdata[DIV_W-1:0]   = div;
         default:         bus_rdata              = '0;
      endcase
   end

endmodule

// File: rtl/spi_bm_clkdiv.sv
module spi_bm_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   // half period of SCK is 2*(div+1) cycles: count 0 .. 2*div+1
   assign limit = {div, 1'b1};
   assign tick  = run && !restart && (cnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (restart || !run)  cnt <= '0;
      else if (cnt == limit)     cnt <= '0;
      else                       cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/spi_bm_engine.sv
module spi_bm_engine
   import spi_bm_pkg::*;
#(
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  cfg_t               cfg,
   input  logic [FRAME_W-1:0] tx_word,
   input  logic               tick,
   input  logic               miso,
   output logic               busy,
   output logic               running,
   output logic               done,
   output logic [FRAME_W-1:0] rx_word,
   output logic               sck,
   output logic               mosi
);

   localparam int EDGES = 2 * FRAME_W;
   localparam int EW    = $clog2(EDGES);
   localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

   eng_st_t            st;
   logic [EW-1:0]      edge_cnt;
   logic               sck_t;
   logic [FRAME_W-1:0] tx_sr, rx_sr;
   logic [FRAME_W-1:0] tx_rev, rx_fin, rx_rev, tx_ld, rx_next;
   logic               leading, last_edge, sample_ev, drive_ev, miso_eff;

   generate
      for (genvar i = 0; i < FRAME_W; i++) begin : g_rev
         assign tx_rev[i] = tx_word[FRAME_W-1-i];
         assign rx_rev[i] = rx_fin[FRAME_W-1-i];
      end
   endgenerate

   assign leading   = ~edge_cnt[0];
   assign last_edge = edge_cnt == LAST_EDGE;
   assign miso_eff  = cfg.loop ? mosi : miso;
   assign sample_ev = tick && (cfg.lead_cap ? leading : ~leading);
   assign drive_ev  = tick && (cfg.lead_cap ? (~leading && !last_edge) : leading);
   assign rx_next   = {rx_sr[FRAME_W-2:0], miso_eff};
   assign rx_fin    = sample_ev ? rx_next : rx_sr;
   assign tx_ld     = cfg.lsb ? tx_rev : tx_word;

   assign done    = tick && last_edge;
   assign rx_word = cfg.lsb ? rx_rev : rx_fin;
   assign busy    = st != ST_IDLE;
   assign running = st == ST_RUN;
   assign sck     = cfg.idle ^ (cfg.en & sck_t);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         edge_cnt <= '0;
         sck_t    <= 1'b0;
         tx_sr    <= '0;
         rx_sr    <= '0;
         mosi     <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               st       <= ST_RUN;
               edge_cnt <= '0;
               sck_t    <= 1'b0;
               rx_sr    <= '0;
               if (cfg.lead_cap) begin
                  mosi  <= tx_ld[FRAME_W-1];
                  tx_sr <= tx_ld << 1;
               end else begin
                  tx_sr <= tx_ld;
               end
            end
            ST_RUN: if (tick) begin
               sck_t    <= ~sck_t;
               edge_cnt <= edge_cnt + 1'b1;
               if (sample_ev) rx_sr <= rx_next;
               if (drive_ev) begin
                  mosi  <= tx_sr[FRAME_W-1];
                  tx_sr <= tx_sr << 1;
               end
               if (last_edge) st <= ST_TAIL;
            end
            ST_TAIL: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
   import spi_bm_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int FRAME_W = 8,
   parameter int DIV_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq,
   output logic              sck,
   output logic              mosi,
   input  logic              miso
);

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must cover offsets 0..6");
      end
      if (FRAME_W < 2 || FRAME_W > REG_W) begin : g_bad_frame
         $error("FRAME_W must lie in 2..8");
      end
      if (DIV_W < 1 || DIV_W > REG_W) begin : g_bad_div
         $error("DIV_W must lie in 1..8");
      end
   endgenerate

   cfg_t               cfg_w;
   logic [FRAME_W-1:0] tx_w, rx_w;
   logic [DIV_W-1:0]   div_w;
   logic               start_ok_w, ready_w, rx_rd_w;
   logic               busy_w, running_w, done_w, tick_w;

   spi_bm_regs #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .DIV_W(DIV_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (reg_addr),
      .bus_wr   (reg_wr),
      .bus_rd   (reg_rd),
      .bus_wdata(reg_wdata),
      .bus_rdata(reg_rdata),
      .busy     (busy_w),
      .done     (done_w),
      .rx_word  (rx_w),
      .cfg      (cfg_w),
      .tx_word  (tx_w),
      .div      (div_w),
      .start_ok (start_ok_w),
      .ready    (ready_w),
      .rx_rd    (rx_rd_w)
   );

   spi_bm_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (running_w),
      .restart(start_ok_w),
      .div    (div_w),
      .tick   (tick_w)
   );

   spi_bm_engine #(.FRAME_W(FRAME_W)) u_eng (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_ok_w),
      .cfg    (cfg_w),
      .tx_word(tx_w),
      .tick   (tick_w),
      .miso   (miso),
      .busy   (busy_w),
      .running(running_w),
      .done   (done_w),
      .rx_word(rx_w),
      .sck    (sck),
      .mosi   (mosi)
   );

   assign irq = ready_w;

endmodule

// File: rtl/spi_bm_checker.sv
module spi_bm_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic ready,
   input logic sck,
   input logic idle_lvl,
   input logic en,
   input logic start_ok,
   input logic rx_rd,
   input logic done,
   input logic tick,
   input logic mosi
);

   // R4: SCK at idle level whenever no frame is in progress
   p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == idle_lvl));

   // R2: accepted start makes the block busy next cycle
   p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> busy);

   // R8: ready rises while busy is still high
   p_ready_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> busy);

   // R8: busy falls one cycle after ready rises
   p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |=> !busy);

   // R9: reading the received byte clears ready
   p_rx_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !done) |=> !ready);

   // R11: with the port disabled an idle block stays idle
   p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !busy) |=> !busy);

   // R5: MOSI changes only on an SCK edge or a start
   p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !start_ok) |=> $stable(mosi));

endmodule

bind spi_byte_master spi_bm_checker u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy_w),
   .ready   (ready_w),
   .sck     (sck),
   .idle_lvl(cfg_w.idle),
   .en      (cfg_w.en),
   .start_ok(start_ok_w),
   .rx_rd   (rx_rd_w),
   .done    (done_w),
   .tick    (tick_w),
   .mosi    (mosi)
);

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;

   localparam int CLK_PER = 10;
   localparam int WDOG    = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq, sck, mosi;
   logic       miso = 1'b0;

   int n_vec = 0;
   int n_bad = 0;

   // slave model controls (bench owned)
   logic [7:0] s_tx = '0;
   logic       s_lead = 1'b0, s_idle = 1'b0, s_lsb = 1'b0, arm = 1'b0;
   // slave model state (slave owned)
   logic [7:0] s_rx = '0;
   logic       arm_seen = 1'b0, sck_prev = 1'b0;
   int         s_edges = 16, s_oi = 0, s_ii = 0;

   always #(CLK_PER/2) clk = ~clk;

   spi_byte_master u_spi_byte_master (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
   );

   function automatic int bpos(input logic lsb, input int k);
      return lsb ? k : 7 - k;
   endfunction

   function automatic logic [7:0] exp_rx(input logic [7:0] mode, input logic [7:0] tx,
                                         input logic [7:0] stx);
      return mode[0] ? tx : stx;
   endfunction

   // SPI slave: reacts half a cycle after each SCK change
   always @(negedge clk) begin
      logic lead;
      sck_prev <= sck;
      if (arm != arm_seen) begin
         arm_seen <= arm;
         s_edges  <= 0;
         s_ii     <= 0;
         s_rx     <= '0;
         if (s_lead) begin
            miso <= s_tx[bpos(s_lsb, 0)];
            s_oi <= 1;
         end else begin
            s_oi <= 0;
         end
      end else if (sck != sck_prev && s_edges < 16) begin
         s_edges <= s_edges + 1;
         lead = (sck != s_idle);
         if (lead == s_lead) begin
            s_rx[bpos(s_lsb, s_ii)] <= mosi;
            s_ii <= s_ii + 1;
         end else if (s_oi < 8) begin
            miso <= s_tx[bpos(s_lsb, s_oi)];
            s_oi <= s_oi + 1;
         end
      end
   end

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic run_xfer(input logic [7:0] mode, input logic [7:0] dv,
                           input logic [7:0] tx, input logic [7:0] stx, input int again);
      int half, total;
      logic [7:0] rd;
      bus_write(3'd0, mode);
      bus_write(3'd6, dv);
      bus_write(3'd2, tx);
      s_tx = stx; s_lead = mode[4]; s_idle = mode[1]; s_lsb = mode[2];
      arm = ~arm;
      @(negedge clk);
      @(negedge clk);
      half  = 2 * (int'(dv) + 1);
      total = 16 * half;
      bus_write(3'd3, 8'h01);
      for (int k = 1; k <= total + 1; k++) begin
         @(negedge clk);
         reg_wr = 1'b0;
         if (k == again) begin   // R10: start while busy
            reg_addr = 3'd3; reg_wdata = 8'h01; reg_wr = 1'b1;
         end
         if (k == half - 1) check("R3 sck before first edge", {7'd0, sck}, {7'd0, mode[1]});
         if (k == half)     check("R3 sck at first edge", {7'd0, sck}, {7'd0, ~mode[1]});
         if (k == total - 1) begin
            reg_addr = 3'd4; #1;
            check("R8 R10 status before completion", reg_rdata, 8'h02);
         end
         if (k == total) begin
            reg_addr = 3'd4; #1;
            check("R8 status at completion", reg_rdata, 8'h03);
            check("R8 irq at completion", {7'd0, irq}, 8'h01);
         end
         if (k == total + 1) begin
            reg_addr = 3'd4; #1;
            check("R8 busy falls", reg_rdata, 8'h01);
         end
      end
      check("R4 sck idle after frame", {7'd0, sck}, {7'd0, mode[1]});
      bus_read(3'd1, rd);
      check(mode[0] ? "R7 loopback rx" : "R5 R6 rx byte", rd, exp_rx(mode, tx, stx));
      check("R5 R6 slave saw tx byte", s_rx, tx);
      reg_addr = 3'd4; #1;
      check("R9 status after rx read", reg_rdata, 8'h00);
      check("R9 irq after rx read", {7'd0, irq}, 8'h00);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      void'($urandom(32'h1A2B3C4D));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      bus_read(3'd4, rd); check("R1 status reset", rd, 8'h00);
      bus_read(3'd0, rd); check("R1 cfg reset", rd, 8'h00);
      bus_read(3'd1, rd); check("R1 rx reset", rd, 8'h00);
      check("R1 irq reset", {7'd0, irq}, 8'h00);
      check("R4 sck reset", {7'd0, sck}, 8'h00);

      // R1: readback and reserved offsets
      bus_write(3'd0, 8'hFF); bus_read(3'd0, rd); check("R1 cfg readback", rd, 8'h1F);
      bus_write(3'd6, 8'hA5); bus_read(3'd6, rd); check("R1 div readback", rd, 8'hA5);
      bus_write(3'd2, 8'h3C); bus_read(3'd2, rd); check("R1 tx readback", rd, 8'h3C);
      bus_read(3'd5, rd); check("R1 offset 5", rd, 8'h00);
      bus_read(3'd7, rd); check("R1 offset 7", rd, 8'h00);

      // R11: start ignored while disabled, idle high
      bus_write(3'd0, 8'h02);
      bus_write(3'd6, 8'h00);
      bus_write(3'd3, 8'h01);
      repeat (40) @(negedge clk);
      reg_addr = 3'd4; #1;
      check("R11 status stays idle", reg_rdata, 8'h00);
      check("R11 no irq", {7'd0, irq}, 8'h00);
      check("R11 R4 sck idle high", {7'd0, sck}, 8'h01);

      // directed frames: each mode, divisor corners, restart while busy
      run_xfer(8'h18, 8'd0,   8'hA5, 8'h3C, 0);   // lead capture, msb first
      run_xfer(8'h08, 8'd1,   8'h81, 8'h7E, 0);   // trailing capture
      run_xfer(8'h1E, 8'd2,   8'h01, 8'h80, 0);   // lsb first, idle high
      run_xfer(8'h0A, 8'd0,   8'hC3, 8'h5A, 5);   // R10 restart at cycle 5
      run_xfer(8'h19, 8'd1,   8'h6D, 8'hFF, 0);   // R7 loopback
      run_xfer(8'h0B, 8'd255, 8'hE1, 8'h00, 0);   // R3 largest divisor

      // R2 R5 R6 R7: random frames
      for (int i = 0; i < 40; i++) begin
         logic [7:0] m, dv, t, s;
         m  = {3'b000, 1'($urandom), 1'b1, 1'($urandom), 1'($urandom), 1'($urandom)};
         dv = 8'($urandom % 6);
         t  = 8'($urandom);
         s  = 8'($urandom);
         run_xfer(m, dv, t, s, (i % 5 == 0) ? 3 : 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule